// File: doc/BRIEF.md
# Unprivileged Instruction Trap Router

This block sits beside the instruction decode of a processor core and decides what happens to a small set of instruction classes issued at the user privilege level (EL0). Each cycle the decode presents at most one instruction class, qualified by a valid strobe. The router combines that class with a hypervisor control image of per-class enable bits, the trap-general-enable flag, the host-extension flag and the current privilege level. It returns one of three outcomes: proceed, trap to the hypervisor level with an exception class and syndrome, or raise an undefined-instruction exception.

The classes covered are the 64-byte atomic load and store family, an access to the second thread-pointer register, and the memory copy/set instructions. The 64-byte store variants share one exception class. The syndrome tells them apart. The outcome is registered, so it appears one cycle after the strobe. Exception entry and priority against other exceptions belong to the consuming pipeline.

Top module: `el0_trap_router`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, trap_o and undef_o are 0 and ec_o and iss_o are all zeros.
- R2: A qualified request for a 64-byte load (cls_i=1) or plain 64-byte store (cls_i=2) with ctrl_i[0]=0 gives trap_o=1, ec_o=0x0A and iss_o=0x0000002 one cycle later.
- R3: A qualified request for a 64-byte store-with-status-to-zero (cls_i=3) with ctrl_i[1]=0 gives trap_o=1, ec_o=0x0A and iss_o=0x0000001. The other enable bits have no effect on it.
- R4: A qualified request for a 64-byte store-with-status (cls_i=4) with ctrl_i[2]=0 gives trap_o=1, ec_o=0x0A and iss_o=0x0000000.
- R5: A qualified access to the thread-pointer-2 register (cls_i=5) with ctrl_i[3]=0 gives trap_o=1, ec_o=0x18 and iss_o=0.
- R6: A qualified memory copy/set request (cls_i=6) with ctrl_i[4]=0, e2h_i=1 and tge_i=1 gives undef_o=1 with trap_o=0 and ec_o and iss_o zero.
- R7: With MOPS_PRESENT=1 and the pair {e2h_i,tge_i} not equal to {1,1}, the memory copy/set enable is taken as 1, so cls_i=6 proceeds even with ctrl_i[4]=0.
- R8: With tge_i=0, no class raises trap_o or undef_o, whatever the value of ctrl_i.
- R9: A request is qualified only when valid_i=1 and el_i=0 (EL0). Otherwise both outputs stay 0.
- R10: A class whose own enable bit is 1 proceeds, with trap_o=0 and undef_o=0.
- R11: The outcome is registered with one cycle of latency. Outputs return to zero in the cycle after a strobe-free cycle.
- R12: The classes cls_i=0 (none) and cls_i=7 (reserved) always proceed. Whenever trap_o and undef_o are both 0, ec_o and iss_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction class strobe |
| cls_i | input | 3 | Instruction class code |
| el_i | input | 2 | Current privilege level, 0 = EL0 |
| tge_i | input | 1 | Trap-general-enable flag |
| e2h_i | input | 1 | Host-extension flag |
| ctrl_i | input | 5 | Per-class enable bits: [0] 64-byte load/store, [1] store-with-status-to-zero, [2] store-with-status, [3] thread-pointer-2, [4] memory copy/set |
| trap_o | output | 1 | Trap to hypervisor level requested |
| ec_o | output | 6 | Exception class of the trap |
| iss_o | output | 25 | Syndrome of the trap |
| undef_o | output | 1 | Undefined-instruction outcome |

## Verification
The assertions check several rules on every cycle. Trap and undefined are never raised together. Idle outputs carry zero class and syndrome. Any trap has a qualified, TGE-enabled request behind it in the previous cycle and reports one of the two legal exception classes. A disabled store-with-status always yields its own syndrome. The bench scenarios are what show the exact class and syndrome of each instruction class, the forced memory copy/set enable, and the enable bits that play no part for a given class. They also show the return to zero after a single strobe and the clearing of outputs on a reset in mid-run.

// File: rtl/el0_trap_pkg.sv
package el0_trap_pkg;
  localparam int CLS_W  = 3;
  localparam int NUM_EN = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 3'd0,
    CLS_LD64   = 3'd1,
    CLS_ST64   = 3'd2,
    CLS_ST64_Z = 3'd3,
    CLS_ST64_S = 3'd4,
    CLS_TP2    = 3'd5,
    CLS_MCS    = 3'd6,
    CLS_RSVD   = 3'd7
  } instr_cls_e;

  // enable bit positions inside the control image
  localparam int EN_LS64  = 0;
  localparam int EN_ST64Z = 1;
  localparam int EN_ST64S = 2;
  localparam int EN_TP2   = 3;
  localparam int EN_MCS   = 4;

  localparam logic [5:0] EC_LS64   = 6'h0A;
  localparam logic [5:0] EC_SYSREG = 6'h18;

  localparam int ISS_LS64  = 2;
  localparam int ISS_ST64Z = 1;
  localparam int ISS_ST64S = 0;
endpackage

// File: rtl/el0_trap_decode.sv
module el0_trap_decode
  import el0_trap_pkg::*;
#(
  parameter int EC_W  = 6,
  parameter int ISS_W = 25,
  parameter int IDX_W = 3
) (
  input  logic [CLS_W-1:0] cls_i,
  output logic             hit_o,
  output logic             undef_kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [EC_W-1:0]  ec_o,
  output logic [ISS_W-1:0] iss_o
);
  instr_cls_e cls;
  assign cls = instr_cls_e'(cls_i);

  always_comb begin
    hit_o        = 1'b1;
    undef_kind_o = 1'b0;
    idx_o        = '0;
    ec_o         = '0;
    iss_o        = '0;
    unique case (cls)
      CLS_LD64, CLS_ST64: begin
        idx_o = IDX_W'(EN_LS64);
        ec_o  = EC_W'(EC_LS64);
        iss_o = ISS_W'(ISS_LS64);
      end
      CLS_ST64_Z: begin
        idx_o = IDX_W'(EN_ST64Z);
        ec_o  = EC_W'(EC_LS64);
        iss_o = ISS_W'(ISS_ST64Z);
      end
      CLS_ST64_S: begin
        idx_o = IDX_W'(EN_ST64S);
        ec_o  = EC_W'(EC_LS64);
        iss_o = ISS_W'(ISS_ST64S);
      end
      CLS_TP2: begin
        idx_o = IDX_W'(EN_TP2);
        ec_o  = EC_W'(EC_SYSREG);
      end
      CLS_MCS: begin
        idx_o        = IDX_W'(EN_MCS);
        undef_kind_o = 1'b1;
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/el0_trap_gate.sv
module el0_trap_gate
  import el0_trap_pkg::*;
#(
  parameter int N_EN         = NUM_EN,
  parameter bit MOPS_PRESENT = 1'b1
) (
  input  logic [N_EN-1:0] ctrl_i,
  input  logic            e2h_i,
  input  logic            tge_i,
  output logic [N_EN-1:0] eff_en_o
);
  logic host_el0;
  assign host_el0 = e2h_i & tge_i;

  for (genvar k = 0; k < N_EN; k++) begin : g_en
    if (k == EN_MCS && MOPS_PRESENT) begin : g_forced
      // outside the host regime the copy/set enable reads as set
      assign eff_en_o[k] = ctrl_i[k] | ~host_el0;
    end else begin : g_plain
      assign eff_en_o[k] = ctrl_i[k];
    end
  end
endmodule

// File: rtl/el0_trap_router.sv
module el0_trap_router
  import el0_trap_pkg::*;
#(
  parameter int EC_W         = 6,
  parameter int ISS_W        = 25,
  parameter int EL_W         = 2,
  parameter int N_EN         = NUM_EN,
  parameter bit MOPS_PRESENT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [EL_W-1:0]  el_i,
  input  logic             tge_i,
  input  logic             e2h_i,
  input  logic [N_EN-1:0]  ctrl_i,
  output logic             trap_o,
  output logic [EC_W-1:0]  ec_o,
  output logic [ISS_W-1:0] iss_o,
  output logic             undef_o
);
  localparam int IDX_W = $clog2(N_EN);

  logic             hit, undef_kind, qual, blocked;
  logic [IDX_W-1:0] idx;
  logic [EC_W-1:0]  ec_d;
  logic [ISS_W-1:0] iss_d;
  logic [N_EN-1:0]  eff_en;
  logic             trap_d, undef_d;

  el0_trap_decode #(.EC_W(EC_W), .ISS_W(ISS_W), .IDX_W(IDX_W)) u_dec (
    .cls_i       (cls_i),
    .hit_o       (hit),
    .undef_kind_o(undef_kind),
    .idx_o       (idx),
    .ec_o        (ec_d),
    .iss_o       (iss_d)
  );

  el0_trap_gate #(.N_EN(N_EN), .MOPS_PRESENT(MOPS_PRESENT)) u_gate (
    .ctrl_i  (ctrl_i),
    .e2h_i   (e2h_i),
    .tge_i   (tge_i),
    .eff_en_o(eff_en)
  );

  assign qual    = valid_i & (el_i == '0) & tge_i;
  assign blocked = qual & hit & ~eff_en[idx];
  assign trap_d  = blocked & ~undef_kind;
  assign undef_d = blocked & undef_kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o  <= 1'b0;
      undef_o <= 1'b0;
      ec_o    <= '0;
      iss_o   <= '0;
    end else begin
      trap_o  <= trap_d;
      undef_o <= undef_d;
      ec_o    <= trap_d ? ec_d : '0;
      iss_o   <= trap_d ? iss_d : '0;
    end
  end
endmodule

// File: rtl/el0_trap_router_chk.sv
module el0_trap_router_chk #(
  parameter int EC_W  = 6,
  parameter int ISS_W = 25,
  parameter int EL_W  = 2,
  parameter int N_EN  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       cls_i,
  input logic [EL_W-1:0]  el_i,
  input logic             tge_i,
  input logic [N_EN-1:0]  ctrl_i,
  input logic             trap_o,
  input logic [EC_W-1:0]  ec_o,
  input logic [ISS_W-1:0] iss_o,
  input logic             undef_o
);
  // R6
  trap_undef_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && undef_o));

  // R12
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_o && !undef_o) |-> (ec_o == '0 && iss_o == '0));

  // R8
  trap_needs_tge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !tge_i) |=> (!trap_o && !undef_o));

  // R9
  trap_needs_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || el_i != '0) |=> (!trap_o && !undef_o));

  // R5
  legal_ec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (ec_o == EC_W'(6'h0A) || ec_o == EC_W'(6'h18)));

  // R4
  st64s_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && el_i == '0 && tge_i && cls_i == 3'd4 && !ctrl_i[2])
      |=> (trap_o && ec_o == EC_W'(6'h0A) && iss_o == '0));
endmodule

bind el0_trap_router el0_trap_router_chk #(
  .EC_W(EC_W), .ISS_W(ISS_W), .EL_W(EL_W), .N_EN(N_EN)
) chk_i (.*);

// File: tb/el0_trap_router_tb_top.sv
module el0_trap_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic        valid;
    logic [2:0]  cls;
    logic [1:0]  el;
    logic        tge;
    logic        e2h;
    logic [4:0]  ctrl;
    logic        trap;
    logic [5:0]  ec;
    logic [24:0] iss;
    logic        undef;
    logic [3:0]  req;
  } vec_t;

  // ctrl bits: [4] copy/set, [3] tp2, [2] st-status, [1] st-status-zero, [0] ld/st
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b1, 6'h0A, 25'd2, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd2, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b1, 6'h0A, 25'd2, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd1, 2'd0, 1'b1, 1'b1, 5'b00001, 1'b0, 6'h00, 25'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 3'd3, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b1, 6'h0A, 25'd1, 1'b0, 4'd3},  // R3
    '{1'b1, 3'd3, 2'd0, 1'b1, 1'b1, 5'b00010, 1'b0, 6'h00, 25'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 3'd3, 2'd0, 1'b1, 1'b1, 5'b11101, 1'b1, 6'h0A, 25'd1, 1'b0, 4'd3},  // R3
    '{1'b1, 3'd4, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b1, 6'h0A, 25'd0, 1'b0, 4'd4},  // R4
    '{1'b1, 3'd4, 2'd0, 1'b1, 1'b1, 5'b00100, 1'b0, 6'h00, 25'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 3'd5, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b1, 6'h18, 25'd0, 1'b0, 4'd5},  // R5
    '{1'b1, 3'd5, 2'd0, 1'b1, 1'b1, 5'b01000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 3'd6, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b1, 4'd6},  // R6
    '{1'b1, 3'd6, 2'd0, 1'b1, 1'b1, 5'b10000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 3'd6, 2'd0, 1'b1, 1'b0, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd7},  // R7
    '{1'b1, 3'd1, 2'd0, 1'b0, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd8},  // R8
    '{1'b1, 3'd6, 2'd0, 1'b0, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd8},  // R8
    '{1'b1, 3'd5, 2'd0, 1'b0, 1'b0, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd8},  // R8
    '{1'b1, 3'd1, 2'd1, 1'b1, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd9},  // R9
    '{1'b1, 3'd4, 2'd2, 1'b1, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd9},  // R9
    '{1'b0, 3'd1, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd9},  // R9
    '{1'b1, 3'd0, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd12}, // R12
    '{1'b1, 3'd7, 2'd0, 1'b1, 1'b1, 5'b00000, 1'b0, 6'h00, 25'd0, 1'b0, 4'd12}, // R12
    '{1'b1, 3'd1, 2'd0, 1'b1, 1'b0, 5'b00000, 1'b1, 6'h0A, 25'd2, 1'b0, 4'd2}   // R2
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  cls_i = '0;
  logic [1:0]  el_i = '0;
  logic        tge_i = 1'b0;
  logic        e2h_i = 1'b0;
  logic [4:0]  ctrl_i = '0;
  logic        trap_o, undef_o;
  logic [5:0]  ec_o;
  logic [24:0] iss_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  el0_trap_router dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cls_i(cls_i),
    .el_i(el_i), .tge_i(tge_i), .e2h_i(e2h_i), .ctrl_i(ctrl_i),
    .trap_o(trap_o), .ec_o(ec_o), .iss_o(iss_o), .undef_o(undef_o)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic check_out(input int req, input logic t, input logic [5:0] e,
                           input logic [24:0] s, input logic u);
    check(req, "trap_o",  {31'd0, trap_o},  {31'd0, t});
    check(req, "ec_o",    {26'd0, ec_o},    {26'd0, e});
    check(req, "iss_o",   {7'd0, iss_o},    {7'd0, s});
    check(req, "undef_o", {31'd0, undef_o}, {31'd0, u});
  endtask

  task automatic drive(input vec_t v);
    valid_i = v.valid; cls_i = v.cls; el_i = v.el;
    tge_i = v.tge; e2h_i = v.e2h; ctrl_i = v.ctrl;
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    // R1: outputs held at zero during reset
    check_out(1, 1'b0, 6'h00, 25'd0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: first cycle after reset
    check_out(1, 1'b0, 6'h00, 25'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check_out(int'(VECS[i].req), VECS[i].trap, VECS[i].ec, VECS[i].iss, VECS[i].undef);
    end

    // R11: single strobe, then outputs clear the next cycle
    drive(VECS[3]);
    @(negedge clk_i);
    check_out(11, 1'b1, 6'h0A, 25'd1, 1'b0);
    valid_i = 1'b0;
    @(negedge clk_i);
    check_out(11, 1'b0, 6'h00, 25'd0, 1'b0);

    // R11: undefined outcome also lasts one cycle
    drive(VECS[10]);
    @(negedge clk_i);
    check(11, "undef_o pulse", {31'd0, undef_o}, 32'd1);
    valid_i = 1'b0;
    @(negedge clk_i);
    check(11, "undef_o clear", {31'd0, undef_o}, 32'd0);

    // R1: reset in mid-run clears a pending trap asynchronously
    drive(VECS[8]);
    @(negedge clk_i);
    check_out(5, 1'b1, 6'h18, 25'd0, 1'b0);
    rst_ni = 1'b0;
    #1;
    check_out(1, 1'b0, 6'h00, 25'd0, 1'b0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule